// File: doc/BRIEF.md
# Bit-Serial Shift Register Adder

This block adds two unsigned operands of `WIDTH` bits, one bit position per clock. Both operands are loaded in parallel into two registers that shift toward the least significant end. Each enabled cycle, a single full adder combines the low bit of each register with a stored carry. The sum bit is shifted into the top of the first operand register, so that register fills with the result. The carry-out is kept in a one-bit register for the next cycle.

The second operand register takes a new bit at its top from a serial input on every shift. This lets a following operand stream in while the current one is consumed. A shift enable gates every update. With the enable low, the whole state holds. After `WIDTH` enabled cycles since the last load, the first register holds the sum, the carry register holds the final carry, and a done flag is raised.

Top module: `serialAdder`

## Requirements
- R1: After reset, the result register output is all zeros, the carry output is 0 and done is 0.
- R2: A cycle with the load input high copies the first operand into the result register and the second operand into the addend register. The same cycle clears the carry output to 0 and drops done.
- R3: When load and shift enable are both high in one cycle, the load is performed and no shift occurs.
- R4: With load and shift enable both low, the result register, the addend register, the carry output and done keep their values, whatever the operand inputs carry.
- R5: Each shift cycle moves the result register one position toward bit 0. Its top bit receives the full-adder sum of its old bit 0, the addend's old bit 0 and the stored carry.
- R6: Each shift cycle stores the full-adder carry-out of the same three bits in the carry output.
- R7: Each shift cycle moves the addend register one position toward bit 0, with the serial input bit entering its top bit.
- R8: After a load and exactly `WIDTH` shift cycles, the result register equals the operand sum modulo 2^`WIDTH`, and the carry output equals bit `WIDTH` of that sum.
- R9: Done rises on the clock that completes the `WIDTH`-th shift since the last load, not earlier. It then stays high until the next load, and further shifts still update the registers.
- R10: With `WIDTH` = 4, loading 1011 and 0101 and shifting four times leaves the result register at 0000 and the carry output at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadOperands | input | 1 | Parallel load of both operands; wins over shifting |
| opA | input | WIDTH | First operand, also the seed of the result register |
| opB | input | WIDTH | Second operand (addend) |
| shiftEn | input | 1 | Enables one serial add step per clock |
| serialInB | input | 1 | Bit entering the top of the addend register on a shift |
| regA | output | WIDTH | Result register contents |
| carryOut | output | 1 | Stored carry |
| done | output | 1 | High once WIDTH shifts have occurred since the last load |

## Verification
The assertions take `WIDTH` to be at least 2 and take every control input to be at a known level after reset. They allow load and shift enable to be high together, because the control module resolves that case into a single strobe. The stimulus changes every input on the falling edge only. It mixes runs of shifts with hold gaps and simultaneous load-and-shift cycles, and it keeps shifting past `WIDTH` so that the saturated done state is covered. A behavioural model of the registers is compared with the outputs after every rising edge.

// File: rtl/serAddPkg.sv
package serAddPkg;
  typedef struct packed {
    logic load;
    logic shift;
  } serAddStrobe_t;
endpackage

// File: rtl/serAddFullAdder.sv
module serAddFullAdder (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  output logic sumBit,
  output logic carryBit
);
  assign sumBit   = inA ^ inB ^ inC;
  assign carryBit = (inA & inB) | (inA & inC) | (inB & inC);
endmodule

// File: rtl/serAddCtrl.sv
module serAddCtrl
  import serAddPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadOperands,
  input  logic          shiftEn,
  output serAddStrobe_t strobe,
  output logic          done
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(WIDTH);

  logic [CNT_W-1:0] shiftCount;

  assign strobe.load  = loadOperands;
  assign strobe.shift = shiftEn & ~loadOperands;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCount <= '0;
    end else if (strobe.load) begin
      shiftCount <= '0;
    end else if (strobe.shift && shiftCount != LAST_COUNT) begin
      shiftCount <= shiftCount + 1'b1;
    end
  end

  assign done = (shiftCount == LAST_COUNT);

  AST_DONE_CLEARED_BY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadOperands |=> !done); // R2
  AST_DONE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!loadOperands && !shiftEn) |=> $stable(done)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (done && !loadOperands) |=> done); // R9
  AST_DONE_RISE_ON_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(shiftEn) && !$past(loadOperands))); // R9
endmodule

// File: rtl/serAddDatapath.sv
module serAddDatapath
  import serAddPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  serAddStrobe_t    strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             serialInB,
  output logic [WIDTH-1:0] regA,
  output logic             carryOut
);
  logic [WIDTH-1:0] regB;
  logic             sumBit;
  logic             carryNext;

  serAddFullAdder i_fullAdder (
    .inA      (regA[0]),
    .inB      (regB[0]),
    .inC      (carryOut),
    .sumBit   (sumBit),
    .carryBit (carryNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA     <= '0;
      regB     <= '0;
      carryOut <= 1'b0;
    end else if (strobe.load) begin
      regA     <= opA;
      regB     <= opB;
      carryOut <= 1'b0;
    end else if (strobe.shift) begin
      regA     <= {sumBit, regA[WIDTH-1:1]};
      regB     <= {serialInB, regB[WIDTH-1:1]};
      carryOut <= carryNext;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.shift)); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (regA == $past(opA) && regB == $past(opB) && !carryOut)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.shift) |=> ($stable(regA) && $stable(regB) && $stable(carryOut))); // R4
  AST_A_MOVES_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (regA[WIDTH-2:0] == $past(regA[WIDTH-1:1]))); // R5
  AST_B_TAKES_SERIAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (regB[WIDTH-1] == $past(serialInB)
                      && regB[WIDTH-2:0] == $past(regB[WIDTH-1:1]))); // R7
endmodule

// File: rtl/serialAdder.sv
module serialAdder
  import serAddPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadOperands,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             shiftEn,
  input  logic             serialInB,
  output logic [WIDTH-1:0] regA,
  output logic             carryOut,
  output logic             done
);
  serAddStrobe_t strobe;

  serAddCtrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .loadOperands (loadOperands),
    .shiftEn      (shiftEn),
    .strobe       (strobe),
    .done         (done)
  );

  serAddDatapath #(.WIDTH(WIDTH)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .serialInB (serialInB),
    .regA      (regA),
    .carryOut  (carryOut)
  );
endmodule

// File: tb/test_serialAdder.sv
`timescale 1ns/1ps
module test_serialAdder;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadOperands = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         shiftEn = 1'b0;
  logic         serialInB = 1'b0;
  logic [W-1:0] regA;
  logic         carryOut;
  logic         done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [W-1:0] mA = '0;
  logic [W-1:0] mB = '0;
  logic         mC = 1'b0;
  int           mCnt = 0;

  always #2.5 clk = ~clk;

  serialAdder #(.WIDTH(W)) i_serialAdder (
    .clk(clk), .rstN(rstN), .loadOperands(loadOperands), .opA(opA), .opB(opB),
    .shiftEn(shiftEn), .serialInB(serialInB), .regA(regA), .carryOut(carryOut), .done(done)
  );

  task automatic checkVal(input string tag, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareModel(input string tag);
    checkVal(tag, int'(regA), int'(mA), "regA");
    checkVal(tag, int'(carryOut), int'(mC), "carryOut");
    checkVal(tag, int'(done), (mCnt == W) ? 1 : 0, "done");
  endtask

  task automatic step(input logic ld, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic sh, input logic si, input string tag);
    int s;
    @(negedge clk);
    loadOperands = ld; opA = a; opB = b; shiftEn = sh; serialInB = si;
    if (ld) begin
      mA = a; mB = b; mC = 1'b0; mCnt = 0;
    end else if (sh) begin
      s = int'(mA[0]) + int'(mB[0]) + int'(mC);
      mA = {s[0], mA[W-1:1]};
      mC = s[1];
      mB = {si, mB[W-1:1]};
      if (mCnt < W) mCnt++;
    end
    @(posedge clk);
    #1;
    compareModel(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int total;
    repeat (3) @(posedge clk);
    #1;
    checkVal("R1", int'(regA), 0, "regA after reset");
    checkVal("R1", int'(carryOut), 0, "carryOut after reset");
    checkVal("R1", int'(done), 0, "done after reset");
    @(negedge clk);
    rstN = 1'b1;

    // R10: worked example
    step(1'b1, 4'b1011, 4'b0101, 1'b0, 1'b0, "R2");
    for (int i = 0; i < W; i++) step(1'b0, '0, '0, 1'b1, 1'b0, "R5");
    checkVal("R10", int'(regA), 0, "example sum");
    checkVal("R10", int'(carryOut), 1, "example carry");

    // R4: idle cycles with changing operand inputs
    for (int i = 0; i < 5; i++) step(1'b0, W'($urandom), W'($urandom), 1'b0, 1'($urandom), "R4");

    // R3: load and shift together
    step(1'b1, 4'b0111, 4'b0011, 1'b1, 1'b1, "R3");
    checkVal("R3", int'(regA), 7, "load wins regA");
    step(1'b0, '0, '0, 1'b1, 1'b0, "R6");
    step(1'b1, 4'b1001, 4'b1111, 1'b1, 1'b0, "R3");
    checkVal("R3", int'(done), 0, "load wins done");

    // R8/R6/R9: exhaustive operand pairs with hold gaps
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        step(1'b1, W'(a), W'(b), 1'b0, 1'b0, "R2");
        for (int k = 0; k < W; k++) begin
          if ($urandom_range(0, 3) == 0) step(1'b0, W'($urandom), W'($urandom), 1'b0, 1'($urandom), "R4");
          step(1'b0, '0, '0, 1'b1, 1'($urandom), (k == W - 1) ? "R9" : "R6");
        end
        total = a + b;
        checkVal("R8", int'(regA), total % (1 << W), "sum bits");
        checkVal("R8", int'(carryOut), (total >> W) & 1, "final carry");
        if ((a + b) % 7 == 0) begin
          step(1'b0, '0, '0, 1'b1, 1'($urandom), "R9");
          checkVal("R9", int'(done), 1, "done after extra shift");
        end
      end
    end

    // R7: stream new addend bits through B and keep adding
    step(1'b1, 4'b0001, 4'b0000, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 3 * W; i++) step(1'b0, '0, '0, 1'b1, 1'(i % 3 == 0), "R7");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule